// File: doc/BRIEF.md
# Saturating Wide Divider

This block divides a 64-bit dividend by a 32-bit divisor over many clock cycles and returns a 32-bit quotient that saturates when the result does not fit. It is the execution unit behind a processor's 32-bit divide instructions. The upper half of the dividend comes from a dedicated high-word register. The lower half is the low word of the first source operand. The divisor is either the second source operand or a 13-bit immediate, which is sign-extended to 32 bits first.

A request is accepted on a `start_i` cycle when the unit is idle. The mode input selects an unsigned or a signed (two's complement) operation. The unit works one quotient bit per cycle by restoring shift-and-subtract. When it finishes, it raises `done_o` for one cycle together with a 64-bit result and a condition-code nibble.

A zero divisor is reported at once through `dz_o`. In that case the result and condition codes keep their previous values.

Top module: `wide_sat_divider`

## Requirements
- R1: The dividend is `{y_hi_i, src1_i}`, where `y_hi_i` supplies bits 63:32.
- R2: With `imm_sel_i`=1 the divisor is `imm_i` sign-extended from 13 to 32 bits, and `src2_i` is ignored. With `imm_sel_i`=0 the divisor is `src2_i`.
- R3: Unsigned mode (`signed_i`=0): if the quotient fits in 32 bits, `result_o` is that quotient zero-extended to 64 bits. Otherwise `result_o` is 64'h0000_0000_FFFF_FFFF.
- R4: Signed mode (`signed_i`=1): the quotient truncates toward zero, and an in-range quotient appears on `result_o` sign-extended to 64 bits.
- R5: Signed mode: a quotient above 2^31-1 gives 64'h0000_0000_7FFF_FFFF.
- R6: Signed mode: a quotient below -2^31 gives 64'hFFFF_FFFF_8000_0000. Exactly -2^31 is not saturated.
- R7: A zero divisor raises `done_o` and `dz_o` together in the cycle after the accepting edge. `busy_o` stays low, and `result_o` and `cc_o` keep their previous values.
- R8: `cc_o` bits are [3]=N, [2]=Z, [1]=V, [0]=C. They are updated on each non-zero completion:
  - N is bit 31 of the final result.
  - Z is set when bits 31:0 of the final result are zero.
  - V is set exactly when saturation occurred.
  - C is 0.
- R9: A non-zero request sets `busy_o` after the accepting edge. `done_o` rises after exactly 65 clock edges counted from that edge and stays high for a single cycle, and `busy_o` falls at the same time.
- R10: A `start_i` while `busy_o` is high is ignored: it neither restarts nor alters the operation in progress.
- R11: After reset, `busy_o`, `done_o`, `dz_o`, `result_o` and `cc_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a division (accepted when idle) |
| signed_i | input | 1 | 1 = signed mode, 0 = unsigned mode |
| imm_sel_i | input | 1 | 1 = divisor from immediate, 0 = from `src2_i` |
| y_hi_i | input | 32 | Dividend high word |
| src1_i | input | 32 | Dividend low word |
| src2_i | input | 32 | Register divisor |
| imm_i | input | 13 | Immediate divisor, sign-extended |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dz_o | output | 1 | Zero divisor, valid with `done_o` |
| result_o | output | 64 | Saturated, extended quotient |
| cc_o | output | 4 | Condition codes {N, Z, V, C} |

## Verification
A wrong quotient bit in the shift register only becomes visible once `done_o` rises, 65 edges after acceptance. Every directed case therefore compares the full 64-bit result and the flag nibble at that single cycle. A corrupted iteration counter shows up as a `done_o` that arrives early, late or twice, so the completion cycle is counted in every case.

A stale sign or mode register appears as a result with the wrong extension of its upper word. This is caught at the same completion cycle, using operand pairs chosen to sit on both sides of each saturation limit. Zero-divisor and busy-start cases look at the ports in the cycles around the event to confirm that nothing previously held has changed.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  typedef enum logic {
    DIV_UNSIGNED = 1'b0,
    DIV_SIGNED   = 1'b1
  } div_mode_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;

endpackage

// File: rtl/sdiv_operand_prep.sv
module sdiv_operand_prep #(
  parameter int W     = 32,
  parameter int IMM_W = 13
) (
  input  logic             signed_i,
  input  logic             imm_sel_i,
  input  logic [W-1:0]     hi_i,
  input  logic [W-1:0]     lo_i,
  input  logic [W-1:0]     src2_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [2*W-1:0]   dvd_mag_o,
  output logic [W-1:0]     dvs_mag_o,
  output logic             neg_o,
  output logic             zero_o
);
  localparam int DW = 2 * W;

  function automatic logic [W-1:0] widen_imm(input logic [IMM_W-1:0] v);
    return {{(W - IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [DW-1:0] abs_dw(input logic [DW-1:0] v, input logic take_neg);
    return take_neg ? (~v + DW'(1)) : v;
  endfunction

  function automatic logic [W-1:0] abs_w(input logic [W-1:0] v, input logic take_neg);
    return take_neg ? (~v + W'(1)) : v;
  endfunction

  logic [DW-1:0] dvd_raw;
  logic [W-1:0]  dvs_raw;
  logic          dvd_neg;
  logic          dvs_neg;

  always_comb begin
    dvd_raw   = {hi_i, lo_i};
    dvs_raw   = imm_sel_i ? widen_imm(imm_i) : src2_i;
    dvd_neg   = signed_i & dvd_raw[DW-1];
    dvs_neg   = signed_i & dvs_raw[W-1];
    dvd_mag_o = abs_dw(dvd_raw, dvd_neg);
    dvs_mag_o = abs_w(dvs_raw, dvs_neg);
    neg_o     = dvd_neg ^ dvs_neg;
    zero_o    = (dvs_raw == '0);
  end

endmodule

// File: rtl/sdiv_restore_core.sv
module sdiv_restore_core #(
  parameter int W  = 32,
  parameter int DW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] dvd_i,
  input  logic [W-1:0]  dvs_i,
  output logic [DW-1:0] quo_o,
  output logic          fin_o
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [W-1:0]  rem_q;
  logic [DW-1:0] q_q;
  logic [W-1:0]  dvs_q;
  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic          fin_q;

  logic [W:0]    trial;
  logic [W+1:0]  diff;
  logic          fits;
  logic [W-1:0]  rem_next;

  always_comb begin
    trial    = {rem_q, q_q[DW-1]};
    diff     = {1'b0, trial} - {2'b00, dvs_q};
    fits     = ~diff[W+1];
    rem_next = fits ? diff[W-1:0] : trial[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      q_q   <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load_i) begin
        rem_q <= '0;
        q_q   <= dvd_i;
        dvs_q <= dvs_i;
        cnt_q <= '0;
        act_q <= 1'b1;
      end else if (act_q) begin
        rem_q <= rem_next;
        q_q   <= {q_q[DW-2:0], fits};
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == LAST) begin
          act_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign quo_o = q_q;
  assign fin_o = fin_q;

endmodule

// File: rtl/sdiv_saturate.sv
module sdiv_saturate #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] mag_i,
  input  logic           neg_i,
  input  logic           signed_i,
  output logic [2*W-1:0] res_o,
  output logic           sat_o
);
  localparam int DW = 2 * W;
  localparam logic [DW-1:0] UMAX    = {{W{1'b0}}, {W{1'b1}}};
  localparam logic [DW-1:0] SMAX    = {{(W + 1){1'b0}}, {(W - 1){1'b1}}};
  localparam logic [DW-1:0] SMIN    = {{(W + 1){1'b1}}, {(W - 1){1'b0}}};
  localparam logic [DW-1:0] NEG_LIM = DW'(1) << (W - 1);

  function automatic logic [DW:0] clamp_unsigned(input logic [DW-1:0] m);
    logic over;
    over = |m[DW-1:W];
    return over ? {1'b1, UMAX} : {1'b0, {W{1'b0}}, m[W-1:0]};
  endfunction

  function automatic logic [DW:0] clamp_signed(input logic [DW-1:0] m, input logic neg);
    logic over;
    if (!neg) begin
      over = |m[DW-1:W-1];
      return over ? {1'b1, SMAX} : {1'b0, m};
    end
    over = (m > NEG_LIM);
    return over ? {1'b1, SMIN} : {1'b0, ~m + DW'(1)};
  endfunction

  logic [DW:0] packed_out;

  always_comb begin
    if (signed_i) packed_out = clamp_signed(mag_i, neg_i);
    else          packed_out = clamp_unsigned(mag_i);
    sat_o = packed_out[DW];
    res_o = packed_out[DW-1:0];
  end

endmodule

// File: rtl/wide_sat_divider.sv
module wide_sat_divider
  import sdiv_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 13,
  parameter bit CC_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             signed_i,
  input  logic             imm_sel_i,
  input  logic [W-1:0]     y_hi_i,
  input  logic [W-1:0]     src1_i,
  input  logic [W-1:0]     src2_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             dz_o,
  output logic [2*W-1:0]   result_o,
  output logic [3:0]       cc_o
);
  localparam int DW = 2 * W;

  // operand preparation
  logic [DW-1:0] dvd_mag;
  logic [W-1:0]  dvs_mag;
  logic          neg_w;
  logic          zero_w;

  sdiv_operand_prep #(.W(W), .IMM_W(IMM_W)) prep_i (
    .signed_i  (signed_i),
    .imm_sel_i (imm_sel_i),
    .hi_i      (y_hi_i),
    .lo_i      (src1_i),
    .src2_i    (src2_i),
    .imm_i     (imm_i),
    .dvd_mag_o (dvd_mag),
    .dvs_mag_o (dvs_mag),
    .neg_o     (neg_w),
    .zero_o    (zero_w)
  );

  // named events for the checker
  logic busy_q;
  logic load_ev;
  logic zero_ev;
  logic fin_ev;

  assign load_ev = start_i & ~busy_q & ~zero_w;
  assign zero_ev = start_i & ~busy_q &  zero_w;

  logic [DW-1:0] quo_w;

  sdiv_restore_core #(.W(W), .DW(DW)) core_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_ev),
    .dvd_i  (dvd_mag),
    .dvs_i  (dvs_mag),
    .quo_o  (quo_w),
    .fin_o  (fin_ev)
  );

  logic      neg_q;
  div_mode_e smode_q;
  logic [DW-1:0] res_w;
  logic          sat_w;

  sdiv_saturate #(.W(W)) sat_i (
    .mag_i    (quo_w),
    .neg_i    (neg_q),
    .signed_i (smode_q == DIV_SIGNED),
    .res_o    (res_w),
    .sat_o    (sat_w)
  );

  logic          done_q;
  logic          dz_q;
  logic [DW-1:0] res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      dz_q    <= 1'b0;
      res_q   <= '0;
      neg_q   <= 1'b0;
      smode_q <= DIV_UNSIGNED;
    end else begin
      done_q <= 1'b0;
      dz_q   <= 1'b0;
      if (zero_ev) begin
        done_q <= 1'b1;
        dz_q   <= 1'b1;
      end
      if (load_ev) begin
        busy_q  <= 1'b1;
        neg_q   <= neg_w;
        smode_q <= signed_i ? DIV_SIGNED : DIV_UNSIGNED;
      end
      if (fin_ev) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        res_q  <= res_w;
      end
    end
  end

  generate
    if (CC_EN) begin : g_cc
      cc_t cc_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cc_q <= '0;
        end else if (fin_ev) begin
          cc_q.n <= res_w[W-1];
          cc_q.z <= (res_w[W-1:0] == '0);
          cc_q.v <= sat_w;
          cc_q.c <= 1'b0;
        end
      end
      assign cc_o = cc_q;
    end else begin : g_no_cc
      assign cc_o = 4'b0000;
    end
  endgenerate

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign dz_o     = dz_q;
  assign result_o = res_q;

endmodule

// File: rtl/sdiv_checker.sv
module sdiv_checker #(
  parameter int W     = 32,
  parameter bit CC_EN = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic           busy_o,
  input logic           done_o,
  input logic           dz_o,
  input logic           cc_v,
  input logic [2*W-1:0] result_o,
  input logic           load_ev,
  input logic           zero_ev,
  input logic           fin_ev,
  input logic           sat_w,
  input logic           smode_q
);
  localparam int DW = 2 * W;
  localparam int RW = $clog2(DW) + 2;

  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_cnt <= '0;
    else if (load_ev) run_cnt <= '0;
    else if (busy_o)  run_cnt <= run_cnt + RW'(1);
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> !done_o);

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fin_ev |-> run_cnt == RW'(DW));

  assert_fin_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fin_ev |=> done_o && !dz_o && !busy_o);

  assert_dz_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dz_o |-> done_o && !busy_o);

  assert_zero_fast_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_ev |=> done_o && dz_o);

  assert_overflow_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !dz_o |-> (!CC_EN) || (cc_v == $past(sat_w)));

  assert_unsigned_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !dz_o && !smode_q |-> result_o[DW-1:W] == '0);

  assert_signed_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !dz_o && smode_q |->
      (result_o[DW-1:W-1] == '0) || (result_o[DW-1:W-1] == '1));

endmodule

bind wide_sat_divider sdiv_checker #(.W(W), .CC_EN(CC_EN)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .dz_o     (dz_o),
  .cc_v     (cc_o[1]),
  .result_o (result_o),
  .load_ev  (load_ev),
  .zero_ev  (zero_ev),
  .fin_ev   (fin_ev),
  .sat_w    (sat_w),
  .smode_q  (smode_q == sdiv_pkg::DIV_SIGNED)
);

// File: tb/wide_sat_divider_tb_top.sv
module wide_sat_divider_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        signed_i = 1'b0;
  logic        imm_sel_i = 1'b0;
  logic [31:0] y_hi_i = '0;
  logic [31:0] src1_i = '0;
  logic [31:0] src2_i = '0;
  logic [12:0] imm_i = '0;
  logic        busy_o;
  logic        done_o;
  logic        dz_o;
  logic [63:0] result_o;
  logic [3:0]  cc_o;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  localparam int EXP_LAT = 65;

  always #2 clk = ~clk;

  wide_sat_divider dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
    .imm_sel_i(imm_sel_i), .y_hi_i(y_hi_i), .src1_i(src1_i), .src2_i(src2_i),
    .imm_i(imm_i), .busy_o(busy_o), .done_o(done_o), .dz_o(dz_o),
    .result_o(result_o), .cc_o(cc_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference: {v, result} restated from the requirements
  function automatic logic [64:0] model(input bit sg, input logic [63:0] dvd,
                                        input logic [31:0] dvs);
    if (!sg) begin
      logic [63:0] q;
      q = dvd / {32'h0, dvs};
      if (q > 64'h0000_0000_FFFF_FFFF) return {1'b1, 64'h0000_0000_FFFF_FFFF};
      return {1'b0, q};
    end else begin
      longint a, b, q;
      a = dvd;
      b = $signed(dvs);
      q = a / b;
      if (q > 64'sh7FFF_FFFF)   return {1'b1, 64'h0000_0000_7FFF_FFFF};
      if (q < -64'sh8000_0000)  return {1'b1, 64'hFFFF_FFFF_8000_0000};
      return {1'b0, q};
    end
  endfunction

  task automatic issue(input bit sg, input bit ims, input logic [31:0] hi,
                       input logic [31:0] lo, input logic [31:0] s2,
                       input logic [12:0] im);
    @(negedge clk);
    signed_i = sg; imm_sel_i = ims; y_hi_i = hi; src1_i = lo;
    src2_i = s2; imm_i = im; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done_o && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  // One full division with every port check at completion
  task automatic run_div(input string req, input bit sg, input bit ims,
                         input logic [31:0] hi, input logic [31:0] lo,
                         input logic [31:0] s2, input logic [12:0] im);
    logic [31:0] dvs;
    logic [64:0] e;
    int n;
    dvs = ims ? {{19{im[12]}}, im} : s2;
    e = model(sg, {hi, lo}, dvs);
    issue(sg, ims, hi, lo, s2, im);
    chk("R9", "busy after accept", 64'(busy_o), 64'd1);
    wait_done(n);
    chk("R9", "completion cycle", 64'(n), 64'(EXP_LAT));
    chk(req, "result", result_o, e[63:0]);
    chk("R8", "cc {N,Z,V,C}", 64'(cc_o),
        64'({e[31], e[31:0] == 32'h0, e[64], 1'b0}));
    chk("R7", "no dz on nonzero divisor", 64'(dz_o), 64'd0);
    @(negedge clk);
    chk("R9", "done single cycle", 64'({done_o, busy_o}), 64'd0);
  endtask

  task automatic t_reset();
    chk("R11", "reset outputs", {56'h0, busy_o, done_o, dz_o, 1'b0, cc_o}, 64'h0);
    chk("R11", "reset result", result_o, 64'h0);
  endtask

  task automatic t_unsigned();
    run_div("R3", 1'b0, 1'b0, 32'h0, 32'd1000, 32'd7, 13'h0);
    run_div("R1", 1'b0, 1'b0, 32'h5, 32'h10, 32'h10, 13'h0);
    chk("R1", "high word used", result_o, 64'h0000_0000_5000_0001);
    run_div("R3", 1'b0, 1'b0, 32'h10, 32'h0, 32'h10, 13'h0);
    chk("R3", "unsigned clamp", result_o, 64'h0000_0000_FFFF_FFFF);
    run_div("R8", 1'b0, 1'b0, 32'h0, 32'd5, 32'd7, 13'h0);
    chk("R8", "zero quotient sets Z", 64'(cc_o), 64'b0100);
  endtask

  task automatic t_immediate();
    // 13'h1FFF sign-extends to 0xFFFFFFFF; src2 holds a decoy
    run_div("R2", 1'b0, 1'b1, 32'h0, 32'hFFFF_FFFF, 32'd5, 13'h1FFF);
    chk("R2", "all-ones immediate divisor", result_o, 64'h1);
    run_div("R2", 1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'd3, 13'd7);
    chk("R2", "signed imm -100/7", result_o, 64'hFFFF_FFFF_FFFF_FFF2);
  endtask

  task automatic t_signed();
    run_div("R4", 1'b1, 1'b0, 32'h0, 32'd100, 32'hFFFF_FFF9, 13'h0);
    chk("R4", "100/-7 truncates", result_o, 64'hFFFF_FFFF_FFFF_FFF2);
    run_div("R4", 1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'd0, 13'h1FF9);
    chk("R4", "-100/-7", result_o, 64'd14);
    run_div("R5", 1'b1, 1'b0, 32'h1, 32'h0, 32'h1, 13'h0);
    chk("R5", "positive clamp", result_o, 64'h0000_0000_7FFF_FFFF);
    run_div("R6", 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h1, 13'h0);
    chk("R6", "negative clamp", result_o, 64'hFFFF_FFFF_8000_0000);
    run_div("R6", 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1, 13'h0);
    chk("R6", "exact minimum no V", 64'(cc_o), 64'b1000);
  endtask

  task automatic t_zero_divisor();
    logic [63:0] prev_res;
    logic [3:0]  prev_cc;
    int n;
    run_div("R4", 1'b1, 1'b0, 32'h0, 32'd100, 32'hFFFF_FFF9, 13'h0);
    prev_res = result_o;
    prev_cc  = cc_o;
    issue(1'b0, 1'b0, 32'h1, 32'h2, 32'h0, 13'h5);
    wait_done(n);
    chk("R7", "dz completion cycle", 64'(n), 64'd0);
    chk("R7", "dz flags", 64'({dz_o, busy_o}), 64'b10);
    chk("R7", "result held", result_o, prev_res);
    chk("R7", "cc held", 64'(cc_o), 64'(prev_cc));
    issue(1'b1, 1'b1, 32'h0, 32'h9, 32'h3, 13'h0);
    chk("R7", "imm zero dz", 64'({done_o, dz_o, busy_o}), 64'b110);
    chk("R7", "result still held", result_o, prev_res);
    @(negedge clk);
  endtask

  task automatic t_busy_start();
    int n;
    issue(1'b0, 1'b0, 32'h0, 32'd1000, 32'd10, 13'h0);
    repeat (9) @(negedge clk);
    signed_i = 1'b1; y_hi_i = 32'h7; src1_i = 32'h3; src2_i = 32'h2; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(n);
    chk("R10", "completion not restarted", 64'(n + 10), 64'(EXP_LAT));
    chk("R10", "first operands kept", result_o, 64'd100);
    @(negedge clk);
    chk("R10", "no second done", 64'({done_o, busy_o}), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_unsigned();
    t_immediate();
    t_signed();
    t_zero_divisor();
    t_busy_start();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule